// File: doc/BRIEF.md
# Chip-Select Cycle Terminator with Acknowledge Time-Out

This block runs one external bus cycle at a time for a single chip-select region. An internal requester pulses a start strobe with an address and a direction. The block then drives the active-low chip-select, and for reads drives the active-low output enable one clock later. It holds the address and the read/write line steady until the cycle ends, and reports completion or failure with a one-clock response pulse.

The cycle can end in one of two ways, chosen per cycle by a configuration input. In internal mode the block counts a programmed number of wait states and ignores the acknowledge pin. In external mode it waits for the active-low acknowledge input, which first passes through a two-flop synchronizer. A bus monitor aborts an external cycle that is still unacknowledged after a fixed number of clocks (1022 by default) and reports a bus error. A region built without acknowledge support always uses internal wait states. After an acknowledged cycle, the block accepts no new request until the synchronized acknowledge has been seen negated.

Top module: `cs_cycle_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, bus_cs_n and bus_oe_n are 1, bus_rw is 1, and rsp_done and rsp_err are 0.
- R2: A req_start seen in the idle state drives bus_cs_n to 0 on the next clock. For the whole cycle, bus_addr and bus_rw hold the values captured at that start, even if req_addr changes. bus_rw is 1 for a read (req_read=1) and 0 for a write.
- R3: On a read, bus_oe_n falls exactly one clock after bus_cs_n falls and rises on the same clock as bus_cs_n. On a write, bus_oe_n stays 1.
- R4: In internal mode (cfg_ext_ack=0) with wait count N, bus_cs_n stays low for exactly min(N, 2^WAIT_W-2)+2 clocks. The largest effective count is 2^WAIT_W-2, which is 1022 at default width.
- R5: In internal mode, bus_ack_n has no effect: holding it low changes neither the cycle length nor the acceptance of the next request.
- R6: In external mode, if bus_ack_n is driven low once bus_cs_n has been low for D clocks, bus_cs_n stays low for D+2 clocks in total and rsp_done pulses. This holds whenever D+2 does not exceed TIMEOUT_CLKS.
- R7: In external mode with no acknowledge seen in time, bus_cs_n stays low for exactly TIMEOUT_CLKS clocks and rsp_err pulses instead of rsp_done.
- R8: rsp_done and rsp_err are single-clock pulses that never assert together. Each appears in the first clock in which bus_cs_n is back at 1.
- R9: After an acknowledged cycle, req_start is ignored while bus_ack_n remains low. A held request starts on the fourth clock after bus_ack_n is released.
- R10: A request seen during an active cycle neither restarts nor extends that cycle.
- R11: When built with EXT_ACK_EN=0, the block ignores cfg_ext_ack=1 and runs internal wait-state timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_ack | input | 1 | 1 = end cycle on external acknowledge, 0 = internal wait states |
| cfg_wait | input | WAIT_W | Programmed wait-state count for internal mode |
| req_start | input | 1 | Start strobe from the internal requester |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Cycle address |
| rsp_done | output | 1 | One-clock pulse: cycle ended normally |
| rsp_err | output | 1 | One-clock pulse: acknowledge time-out bus error |
| bus_addr | output | ADDR_W | Address held on the external bus |
| bus_cs_n | output | 1 | Active-low chip-select |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_rw | output | 1 | High for read, low for write; idles high |
| bus_ack_n | input | 1 | Asynchronous active-low external acknowledge |

## Verification
The bench builds the block with WAIT_W=4 and TIMEOUT_CLKS=24. At these sizes it can sweep every wait count, including the one above the clamp limit of 14, for both reads and writes. It can also sweep every acknowledge delay from the first clock of chip-select to past the time-out point, so it covers both the last delay that still ends with done and the first one that ends with a bus error. A second instance built with EXT_ACK_EN=0 runs beside it to show that a region without acknowledge support falls back to wait-state timing.

// File: rtl/cs_cycle_pkg.sv
package cs_cycle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } cyc_state_e;

  // Effective wait-state count after clamping to the region maximum.
  function automatic int unsigned eff_wait(input int unsigned req,
                                           input int unsigned max_wait);
    return (req > max_wait) ? max_wait : req;
  endfunction

  // Counter value at which an internally timed cycle terminates.
  // The counter reads k-1 at the k-th edge after chip-select falls,
  // so the cycle lasts eff_wait + 2 clocks.
  function automatic int unsigned wait_end_count(input int unsigned req,
                                                 input int unsigned max_wait);
    return eff_wait(req, max_wait) + 1;
  endfunction

  // Counter value at which an unacknowledged external cycle is aborted.
  function automatic int unsigned timeout_end_count(input int unsigned limit);
    return limit - 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cs_ack_sync.sv
module cs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic dout_n
);
  logic stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else        stage_q[g] <= din_n;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout_n = stage_q[STAGES-1];
endmodule

// File: rtl/cs_cycle_timer.sv
module cs_cycle_timer #(
  parameter int CNT_W        = 11,
  parameter int TIMEOUT_CLKS = 1022
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] wait_lim,
  output logic             wait_hit,
  output logic             tmo_hit
);
  import cs_cycle_pkg::*;

  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(timeout_end_count(TIMEOUT_CLKS));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign wait_hit = (cnt_q == wait_lim);
  assign tmo_hit  = (cnt_q == TMO_LAST);
endmodule

// File: rtl/cs_cycle_fsm.sv
module cs_cycle_fsm
  import cs_cycle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd,
  input  logic ext_sel,
  input  logic wait_hit,
  input  logic tmo_hit,
  input  logic ack_seen,
  output logic accept,
  output logic cnt_inc,
  output logic cyc_end,
  output logic in_drain,
  output logic mode_ext,
  output logic rd_q,
  output logic cs_n,
  output logic oe_n,
  output logic done,
  output logic err
);
  cyc_state_e st_q, st_d;
  logic active, end_ack, end_wait, end_tmo;

  always_comb begin
    active   = (st_q == ST_ACTIVE);
    accept   = (st_q == ST_IDLE) && start;
    in_drain = (st_q == ST_DRAIN);
    end_ack  = active &&  mode_ext && ack_seen;
    end_wait = active && !mode_ext && wait_hit;
    end_tmo  = active &&  mode_ext && !ack_seen && tmo_hit;
    cyc_end  = end_ack || end_wait || end_tmo;
    cnt_inc  = active && !cyc_end;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_ACTIVE;
      ST_ACTIVE: if (end_ack) st_d = ST_DRAIN;
                 else if (cyc_end) st_d = ST_IDLE;
      ST_DRAIN:  if (!ack_seen) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mode_ext <= 1'b0;
      rd_q     <= 1'b1;
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= end_ack || end_wait;
      err  <= end_tmo;
      if (accept) begin
        mode_ext <= ext_sel;
        rd_q     <= rd;
        cs_n     <= 1'b0;
      end else if (cyc_end) begin
        cs_n     <= 1'b1;
      end
      if (cyc_end)             oe_n <= 1'b1;
      else if (active && rd_q) oe_n <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_cycle_ctrl.sv
module cs_cycle_ctrl #(
  parameter int ADDR_W       = 25,
  parameter int WAIT_W       = 10,
  parameter int TIMEOUT_CLKS = 1022,
  parameter int SYNC_STAGES  = 2,
  parameter bit EXT_ACK_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_ack,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_start,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_rw,
  input  logic              bus_ack_n
);
  import cs_cycle_pkg::*;

  localparam int unsigned MAX_WAIT = (2 ** WAIT_W) - 2;
  localparam int unsigned SPAN     = max2(TIMEOUT_CLKS, MAX_WAIT + 2);
  localparam int          CNT_W    = $clog2(SPAN + 1);

  logic             ack_sync_n, ack_seen;
  logic             ext_sel;
  logic             accept, cnt_inc, cyc_end, in_drain, mode_ext, rd_q;
  logic             wait_hit, tmo_hit;
  logic [CNT_W-1:0] wait_lim_d, wait_lim_q;
  logic [ADDR_W-1:0] addr_q;

  cs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_n  (bus_ack_n),
    .dout_n (ack_sync_n)
  );
  assign ack_seen = ~ack_sync_n;

  if (EXT_ACK_EN) begin : g_ext_capable
    assign ext_sel = cfg_ext_ack;
  end else begin : g_int_only
    assign ext_sel = 1'b0;
  end

  assign wait_lim_d = CNT_W'(wait_end_count(32'(cfg_wait), MAX_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wait_lim_q <= '0;
    end else if (accept) begin
      addr_q     <= req_addr;
      wait_lim_q <= wait_lim_d;
    end
  end

  cs_cycle_timer #(.CNT_W(CNT_W), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .inc      (cnt_inc),
    .wait_lim (wait_lim_q),
    .wait_hit (wait_hit),
    .tmo_hit  (tmo_hit)
  );

  cs_cycle_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (req_start),
    .rd       (req_read),
    .ext_sel  (ext_sel),
    .wait_hit (wait_hit),
    .tmo_hit  (tmo_hit),
    .ack_seen (ack_seen),
    .accept   (accept),
    .cnt_inc  (cnt_inc),
    .cyc_end  (cyc_end),
    .in_drain (in_drain),
    .mode_ext (mode_ext),
    .rd_q     (rd_q),
    .cs_n     (bus_cs_n),
    .oe_n     (bus_oe_n),
    .done     (rsp_done),
    .err      (rsp_err)
  );

  assign bus_addr = addr_q;
  assign bus_rw   = bus_cs_n | rd_q;
endmodule

// File: rtl/cs_cycle_chk.sv
module cs_cycle_chk #(
  parameter int ADDR_W       = 25,
  parameter int WAIT_W       = 10,
  parameter int TIMEOUT_CLKS = 1022
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic              done,
  input logic              err,
  input logic              ack_seen,
  input logic              mode_ext,
  input logic              in_drain
);
  localparam int unsigned LIMIT = (TIMEOUT_CLKS > (2 ** WAIT_W))
                                  ? TIMEOUT_CLKS : (2 ** WAIT_W);

  int unsigned lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_cnt <= 0;
    else if (cs_n) lo_cnt <= 0;
    else           lo_cnt <= lo_cnt + 1;
  end

  // R3
  oe_within_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n);
  // R3
  oe_delayed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> ($past(!cs_n) && !cs_n));
  // R3
  no_oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rw) |-> oe_n);
  // R2
  addr_rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(rw)));
  // R8
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R8
  resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));
  // R8
  resp_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> $rose(cs_n));
  // R6
  ack_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_ext) |-> $past(ack_seen));
  // R7
  err_only_external_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> mode_ext);
  // R7
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= LIMIT);
  // R9
  drain_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain |-> cs_n);
endmodule

bind cs_cycle_ctrl cs_cycle_chk #(
  .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .TIMEOUT_CLKS(TIMEOUT_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (bus_cs_n),
  .oe_n     (bus_oe_n),
  .rw       (bus_rw),
  .addr     (bus_addr),
  .done     (rsp_done),
  .err      (rsp_err),
  .ack_seen (ack_seen),
  .mode_ext (mode_ext),
  .in_drain (in_drain)
);

// File: tb/cs_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module cs_cycle_ctrl_bench;
  localparam int AW  = 12;
  localparam int WW  = 4;
  localparam int TMO = 24;
  localparam int MAXW = (2 ** WW) - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext = 1'b0;
  logic [WW-1:0] cfg_wait = '0;
  logic start = 1'b0, start2 = 1'b0, rd = 1'b1, ack_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic done, err, cs_n, oe_n, rw;
  logic [AW-1:0] baddr;
  logic done2, err2, cs2_n, oe2_n, rw2;
  logic [AW-1:0] baddr2;

  int checks = 0, failures = 0, seed = 1;

  always #5 clk = ~clk;

  cs_cycle_ctrl #(.ADDR_W(AW), .WAIT_W(WW), .TIMEOUT_CLKS(TMO), .EXT_ACK_EN(1'b1)) u_cs_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_ext_ack(cfg_ext), .cfg_wait(cfg_wait),
    .req_start(start), .req_read(rd), .req_addr(addr),
    .rsp_done(done), .rsp_err(err), .bus_addr(baddr),
    .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_rw(rw), .bus_ack_n(ack_n));

  cs_cycle_ctrl #(.ADDR_W(AW), .WAIT_W(WW), .TIMEOUT_CLKS(TMO), .EXT_ACK_EN(1'b0)) u_noack (
    .clk(clk), .rst_n(rst_n), .cfg_ext_ack(cfg_ext), .cfg_wait(cfg_wait),
    .req_start(start2), .req_read(rd), .req_addr(addr),
    .rsp_done(done2), .rsp_err(err2), .bus_addr(baddr2),
    .bus_cs_n(cs2_n), .bus_oe_n(oe2_n), .bus_rw(rw2), .bus_ack_n(ack_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_int_len(input int n);
    return ((n > MAXW) ? MAXW : n) + 2;
  endfunction

  function automatic int exp_ext_len(input int d);
    if (d == 0 || d + 2 > TMO) return TMO;
    return d + 2;
  endfunction

  // Runs one cycle; measures chip-select/OE low time and response pulses.
  task automatic run_cycle(input bit rd_i, input bit ext_i, input int wv,
                           input int ack_at, input bit ack_low_all, input bit keep_ack,
                           input bit mid_start,
                           output int cs_lo, output int oe_lo,
                           output int n_done, output int n_err,
                           output bit f_done, output bit f_err, output bit hold_ok);
    logic [AW-1:0] a;
    a = AW'(seed * 37 + 5);
    seed++;
    cs_lo = 0; oe_lo = 0; hold_ok = 1'b1;
    @(negedge clk);
    cfg_ext = ext_i; cfg_wait = WW'(wv); rd = rd_i; addr = a; start = 1'b1;
    ack_n = ~ack_low_all;
    @(negedge clk);
    start = 1'b0; addr = ~a;
    for (int i = 0; i < TMO + 40; i++) begin
      if (cs_n !== 1'b0) break;
      cs_lo++;
      if (oe_n === 1'b0) oe_lo++;
      if (rw !== rd_i || baddr !== a || done || err) hold_ok = 1'b0;
      if (ack_at != 0 && cs_lo == ack_at) ack_n = 1'b0;
      start = (mid_start && cs_lo == 2);
      @(negedge clk);
    end
    start = 1'b0;
    f_done = done; f_err = err;
    n_done = int'(done); n_err = int'(err);
    repeat (2) begin
      @(negedge clk);
      n_done += int'(done); n_err += int'(err);
    end
    if (!keep_ack && !ack_low_all) ack_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cl, ol, nd, ne, e;
    bit fd, fe, hk;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1 && oe_n === 1 && rw === 1 && done === 0 && err === 0,
        "R1 reset outputs", {cs_n, oe_n, rw, done, err}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1 && oe_n === 1 && rw === 1 && done === 0 && err === 0,
        "R1 after release", {cs_n, oe_n, rw, done, err}, 5'b11100);

    // R4 R3 R2 R8: full internal sweep, reads and writes, clamp included
    for (int n = 0; n < 2 ** WW; n++) begin
      for (int r = 0; r < 2; r++) begin
        run_cycle(r[0], 1'b0, n, 0, 1'b0, 1'b0, 1'b0, cl, ol, nd, ne, fd, fe, hk);
        e = exp_int_len(n);
        chk(cl == e, "R4 internal cs length", cl, e);
        chk(ol == (r ? e - 1 : 0), "R3 oe length", ol, r ? e - 1 : 0);
        chk(hk, "R2 addr/rw held", int'(hk), 1);
        chk(fd && !fe && nd == 1 && ne == 0, "R8 done pulse", nd * 10 + ne, 10);
      end
    end

    // R6 R7 R8: external acknowledge delay sweep, 0 = never acknowledged
    for (int d = 0; d <= TMO; d++) begin
      run_cycle(1'b1, 1'b1, 3, d, 1'b0, 1'b0, 1'b0, cl, ol, nd, ne, fd, fe, hk);
      e = exp_ext_len(d);
      chk(cl == e, (d != 0 && d + 2 <= TMO) ? "R6 ack cs length" : "R7 timeout cs length", cl, e);
      chk(ol == e - 1, "R3 oe length ext", ol, e - 1);
      if (d != 0 && d + 2 <= TMO)
        chk(fd && !fe && nd == 1 && ne == 0, "R6 done on ack", nd * 10 + ne, 10);
      else
        chk(fe && !fd && ne == 1 && nd == 0, "R7 error on timeout", nd * 10 + ne, 1);
    end

    // R10: request in mid-cycle neither restarts nor extends
    run_cycle(1'b0, 1'b0, 6, 0, 1'b0, 1'b0, 1'b1, cl, ol, nd, ne, fd, fe, hk);
    chk(cl == exp_int_len(6), "R10 mid-cycle start ignored", cl, exp_int_len(6));
    chk(nd == 1 && ne == 0, "R10 single response", nd, 1);
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1, "R10 no extra cycle", int'(cs_n), 1);

    // R5: acknowledge held low during internal cycle is ignored
    run_cycle(1'b1, 1'b0, 5, 0, 1'b1, 1'b1, 1'b0, cl, ol, nd, ne, fd, fe, hk);
    chk(cl == exp_int_len(5), "R5 internal length with ack low", cl, exp_int_len(5));
    chk(fd && !fe, "R5 done not error", int'(fd), 1);
    start = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b0, "R5 next start accepted with ack low", int'(cs_n), 0);
    start = 1'b0;
    repeat (30) @(negedge clk);
    ack_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: no new cycle until acknowledge is negated
    run_cycle(1'b1, 1'b1, 0, 3, 1'b0, 1'b1, 1'b0, cl, ol, nd, ne, fd, fe, hk);
    chk(cl == 5 && fd, "R9 acked cycle", cl, 5);
    start = 1'b1;
    hk = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (cs_n !== 1'b1) hk = 1'b0;
    end
    chk(hk, "R9 start blocked while ack low", int'(hk), 1);
    ack_n = 1'b1;
    hk = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (cs_n !== 1'b1) hk = 1'b0;
    end
    chk(hk, "R9 still idle during sync", int'(hk), 1);
    @(negedge clk);
    chk(cs_n === 1'b0, "R9 start on fourth clock", int'(cs_n), 0);
    start = 1'b0;
    repeat (TMO + 10) @(negedge clk);

    // R11: region without acknowledge support uses wait states
    cfg_ext = 1'b1; cfg_wait = WW'(5); ack_n = 1'b1;
    start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    cl = 0; nd = 0; ne = 0;
    for (int i = 0; i < TMO + 10; i++) begin
      if (cs2_n === 1'b0) cl++;
      nd += int'(done2); ne += int'(err2);
      @(negedge clk);
    end
    chk(cl == exp_int_len(5), "R11 internal timing forced", cl, exp_int_len(5));
    chk(nd == 1 && ne == 0, "R11 done without ack", nd * 10 + ne, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule